// File: doc/BRIEF.md
# SDRAM Low-Power State Sequencer

This block sits beside the main command logic of a controller for a two-bank SDRAM. It owns the clock-enable pin and the four command strobes, and it moves the memory between normal operation and three quiet states. Those states are self-refresh, power-down and clock suspend. A host raises a level request for each quiet state. The main controller reports whether both banks are idle and whether a read or write burst is in flight. While no quiet state is active, the sequencer holds clock-enable high and drives deselect, so the main controller owns the bus.

Leaving a quiet state always passes through a recovery window of NOP commands with clock-enable high. Self-refresh uses the row-cycle time for this window. Power-down and clock suspend use the clock-enable recovery time. After self-refresh, the memory cannot report which row it refreshed last. For that reason the sequencer then issues a full sweep of auto-refresh commands, spaced one row-cycle apart.

Power-down and clock suspend do not refresh the array. A deadline counter therefore wakes the memory a configurable margin before the refresh period runs out. After such a forced wake, the host must release its request before the same state can be entered again. A `busy` output stays high from entry until the memory is back in normal operation.

Top module: `sdram_lp_seq`

## Requirements
- R1: After reset, cke is 1, the strobes {cs_n,ras_n,cas_n,we_n} show deselect 4'b1111 and busy is 0. The same output holds in every normal-operation cycle.
- R2: Self-refresh is entered when req_sleep and banks_idle are both high in normal operation. In the next cycle cke is 0 with strobes 4'b0001 for exactly one cycle. After that cke stays 0 with deselect 4'b1111 for as long as req_sleep is high. Without banks_idle, the state is not entered.
- R3: One cycle after req_sleep is sampled low in self-refresh, cke returns to 1. For TRC_CYC cycles the strobes then show NOP 4'b0111.
- R4: Straight after that recovery, exactly REF_COUNT auto-refresh commands are issued (cke 1, strobes 4'b0001). The first comes in the first cycle after recovery, and each later one follows TRC_CYC cycles after the previous one, with NOP between them. One further NOP cycle comes after the last gap, and then normal operation resumes.
- R5: Power-down is entered when req_pdown and banks_idle are both high: the next cycle has cke 0 with deselect. When banks_idle is low, it is not entered.
- R6: Clock suspend is entered when req_susp and burst_active are both high: the next cycle has cke 0 with deselect.
- R7: While in power-down or clock suspend, banks_idle, burst_active and the requests for the other states have no effect. cke stays 0 and the strobes stay at deselect.
- R8: One cycle after the request that holds power-down or clock suspend is sampled low, cke returns to 1. NOP then follows for TCKA_CYC cycles, after which normal operation resumes.
- R9: Power-down or clock suspend lasts at most TREF_CYC minus MARGIN_CYC cycles with cke 0. When that limit is reached, the NOP recovery of R8 starts even if the request is still high.
- R10: After a forced wake, req_pdown and req_susp are ignored until both have been sampled low in normal operation.
- R11: busy is 1 in every cycle outside normal operation, including self-refresh, recovery and the whole refresh sweep.
- R12: Requests rank sleep over power-down over suspend. A higher-ranked request that is present masks the lower ones, even when its own entry condition is not met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_sleep | input | 1 | Host request for self-refresh (level) |
| req_pdown | input | 1 | Host request for power-down (level) |
| req_susp | input | 1 | Host request for clock suspend (level) |
| banks_idle | input | 1 | Both banks precharged, from the main controller |
| burst_active | input | 1 | A read or write burst is in progress |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| busy | output | 1 | Sequencer owns the memory |

## Verification
On every cycle, the assertions check the following. A self-refresh command is followed by clock-enable low with deselect. Every rise of clock-enable carries a NOP. Clock-enable never falls without a qualifying request and condition. No quiet state other than self-refresh stays low longer than the deadline window. A forced wake is followed by NOP recovery. busy is high whenever clock-enable is low or a refresh is issued. Other properties can only be shown by the bench's scenarios against its cycle model: the exact length of each recovery window, the count and spacing of the refresh sweep, the masking order of requests, and the lock that follows a forced wake.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SR_ENTER,
    ST_SR,
    ST_SR_REC,
    ST_SWEEP,
    ST_PD,
    ST_SUSP,
    ST_WAKE
  } lp_state_e;

  // strobe codes as {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_DESEL   = 4'b1111;
  localparam logic [3:0] CMD_NOP     = 4'b0111;
  localparam logic [3:0] CMD_REFRESH = 4'b0001;

  // pin image {cke, cs_n, ras_n, cas_n, we_n} for a state
  function automatic logic [4:0] pins_for(lp_state_e st, logic aref);
    logic [4:0] p;
    case (st)
      ST_RUN:                 p = {1'b1, CMD_DESEL};
      ST_SR_ENTER:            p = {1'b0, CMD_REFRESH};
      ST_SR, ST_PD, ST_SUSP:  p = {1'b0, CMD_DESEL};
      ST_SR_REC, ST_WAKE:     p = {1'b1, CMD_NOP};
      ST_SWEEP:               p = {1'b1, aref ? CMD_REFRESH : CMD_NOP};
      default:                p = {1'b1, CMD_DESEL};
    endcase
    return p;
  endfunction

  // cycles a low-power state may hold cke low before a forced wake
  function automatic int unsigned wake_window(int unsigned tref, int unsigned margin);
    return (tref > margin + 1) ? (tref - margin) : 1;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lp_downcount.sv
module lp_downcount #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/lp_sweep.sv
module lp_sweep #(
  parameter int REF_COUNT = 4096,
  parameter int GAP       = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic fire,
  output logic done
);
  localparam int LW = $clog2(REF_COUNT + 1);
  localparam int GW = $clog2(GAP + 1);
  localparam logic [LW-1:0] LEFT_INIT = LW'(REF_COUNT);
  localparam logic [GW-1:0] GAP_INIT  = GW'(GAP - 1);

  logic [LW-1:0] left;
  logic [GW-1:0] gap;
  logic          slot;

  assign slot = (gap == '0);
  assign fire = active && slot && (left != '0);
  assign done = active && slot && (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
      gap  <= '0;
    end else if (start) begin
      left <= LEFT_INIT;
      gap  <= '0;
    end else if (active) begin
      if (fire) begin
        left <= left - 1'b1;
        gap  <= GAP_INIT;
      end else if (!slot) begin
        gap  <= gap - 1'b1;
      end
    end
  end
endmodule

// File: rtl/lp_pin_encode.sv
module lp_pin_encode
  import sdram_lp_pkg::*;
(
  input  lp_state_e st,
  input  logic      aref,
  output logic      cke,
  output logic      cs_n,
  output logic      ras_n,
  output logic      cas_n,
  output logic      we_n
);
  always_comb begin
    {cke, cs_n, ras_n, cas_n, we_n} = pins_for(st, aref);
  end
endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
  import sdram_lp_pkg::*;
#(
  parameter int TRC_CYC    = 7,
  parameter int TCKA_CYC   = 2,
  parameter int TREF_CYC   = 640000,
  parameter int MARGIN_CYC = 64,
  parameter int REF_COUNT  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_sleep,
  input  logic req_pdown,
  input  logic req_susp,
  input  logic banks_idle,
  input  logic burst_active,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic busy
);
  localparam int unsigned WIN  = wake_window(TREF_CYC, MARGIN_CYC);
  localparam int unsigned RMAX = max2(TRC_CYC, TCKA_CYC);
  localparam int RW = $clog2(RMAX + 1);
  localparam int DW = $clog2(WIN + 1);
  localparam logic [RW-1:0] REC_SR   = RW'(TRC_CYC - 1);
  localparam logic [RW-1:0] REC_WAKE = RW'(TCKA_CYC - 1);
  localparam logic [DW-1:0] DL_INIT  = DW'(WIN - 1);

  lp_state_e st, st_nxt;
  logic          rec_load, rec_zero;
  logic [RW-1:0] rec_val;
  logic          dl_load, dl_zero;
  logic          sweep_start, aref_fire, sweep_done;
  logic          force_wake;
  logic          lock;
  logic          hold_req;

  // request that keeps the current cke-low state alive
  assign hold_req = (st == ST_PD) ? req_pdown : req_susp;

  always_comb begin
    st_nxt      = st;
    rec_load    = 1'b0;
    rec_val     = REC_WAKE;
    dl_load     = 1'b0;
    sweep_start = 1'b0;
    force_wake  = 1'b0;
    case (st)
      ST_RUN: begin
        if (req_sleep) begin
          if (banks_idle) st_nxt = ST_SR_ENTER;
        end else if (req_pdown) begin
          if (banks_idle && !lock) begin
            st_nxt  = ST_PD;
            dl_load = 1'b1;
          end
        end else if (req_susp && burst_active && !lock) begin
          st_nxt  = ST_SUSP;
          dl_load = 1'b1;
        end
      end
      ST_SR_ENTER: st_nxt = ST_SR;
      ST_SR: begin
        if (!req_sleep) begin
          st_nxt   = ST_SR_REC;
          rec_load = 1'b1;
          rec_val  = REC_SR;
        end
      end
      ST_SR_REC: begin
        if (rec_zero) begin
          st_nxt      = ST_SWEEP;
          sweep_start = 1'b1;
        end
      end
      ST_SWEEP: begin
        if (sweep_done) st_nxt = ST_RUN;
      end
      ST_PD, ST_SUSP: begin
        if (!hold_req || dl_zero) begin
          st_nxt     = ST_WAKE;
          rec_load   = 1'b1;
          force_wake = hold_req;
        end
      end
      ST_WAKE: begin
        if (rec_zero) st_nxt = ST_RUN;
      end
      default: st_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_RUN;
      lock <= 1'b0;
    end else begin
      st <= st_nxt;
      if (force_wake)
        lock <= 1'b1;
      else if (st == ST_RUN && !req_pdown && !req_susp)
        lock <= 1'b0;
    end
  end

  lp_downcount #(.W(RW)) u_rec (
    .clk(clk), .rst_n(rst_n), .load(rec_load), .load_val(rec_val), .zero(rec_zero)
  );

  lp_downcount #(.W(DW)) u_deadline (
    .clk(clk), .rst_n(rst_n), .load(dl_load), .load_val(DL_INIT), .zero(dl_zero)
  );

  lp_sweep #(.REF_COUNT(REF_COUNT), .GAP(TRC_CYC)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(sweep_start), .active(st == ST_SWEEP),
    .fire(aref_fire), .done(sweep_done)
  );

  lp_pin_encode u_pins (
    .st(st), .aref(aref_fire),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  assign busy = (st != ST_RUN);

endmodule

// File: rtl/sdram_lp_seq_chk.sv
module sdram_lp_seq_chk #(
  parameter int TREF_CYC   = 640000,
  parameter int MARGIN_CYC = 64
) (
  input logic clk,
  input logic rst_n,
  input logic req_pdown,
  input logic req_susp,
  input logic banks_idle,
  input logic burst_active,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic busy,
  input logic force_wake
);
  localparam int unsigned WIN = sdram_lp_pkg::wake_window(TREF_CYC, MARGIN_CYC);
  localparam int CW = $clog2(WIN + 2);

  logic sref_now, aref_now, nop_now, sr_mode;
  logic [CW-1:0] low_run;

  assign sref_now = !cke && !cs_n && !ras_n && !cas_n && we_n;
  assign aref_now =  cke && !cs_n && !ras_n && !cas_n && we_n;
  assign nop_now  = !cs_n && ras_n && cas_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_mode <= 1'b0;
      low_run <= '0;
    end else begin
      if (cke)           sr_mode <= 1'b0;
      else if (sref_now) sr_mode <= 1'b1;
      if (cke || sr_mode || sref_now) low_run <= '0;
      else if (low_run <= CW'(WIN)) low_run <= low_run + 1'b1;
    end
  end

  // R2
  a_r2_sref_then_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sref_now |=> (!cke && cs_n));

  // R3 / R8
  a_r3_rise_with_nop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> nop_now);

  // R5 / R6
  a_r5_entry_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cke) && cs_n) |-> ($past(req_pdown && banks_idle) || $past(req_susp && burst_active)));

  // R9
  a_r9_low_window: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= CW'(WIN));

  // R9
  a_r9_forced_wake_nop: assert property (@(posedge clk) disable iff (!rst_n)
    force_wake |=> (cke && nop_now));

  // R11
  a_r11_busy_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> busy);

  // R4 / R11
  a_r4_aref_busy: assert property (@(posedge clk) disable iff (!rst_n)
    aref_now |-> busy);

endmodule

bind sdram_lp_seq sdram_lp_seq_chk #(.TREF_CYC(TREF_CYC), .MARGIN_CYC(MARGIN_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_pdown(req_pdown), .req_susp(req_susp),
  .banks_idle(banks_idle), .burst_active(burst_active),
  .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .busy(busy), .force_wake(force_wake)
);

// File: tb/sdram_lp_seq_test.sv
`timescale 1ns/1ps
module sdram_lp_seq_test;
  localparam int TRC = 3, TCKA = 2, TREF = 40, MARGIN = 10, NREF = 5;
  localparam int WIN = TREF - MARGIN;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_sleep = 0, req_pdown = 0, req_susp = 0, banks_idle = 0, burst_active = 0;
  logic cke, cs_n, ras_n, cas_n, we_n, busy;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sdram_lp_seq #(.TRC_CYC(TRC), .TCKA_CYC(TCKA), .TREF_CYC(TREF),
                 .MARGIN_CYC(MARGIN), .REF_COUNT(NREF)) uut (
    .clk(clk), .rst_n(rst_n), .req_sleep(req_sleep), .req_pdown(req_pdown),
    .req_susp(req_susp), .banks_idle(banks_idle), .burst_active(burst_active),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .busy(busy));

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model: phase + elapsed cycles ----------------
  // phases: 0 run, 1 sref cmd, 2 self-refresh, 3 sr recovery, 4 sweep, 5 pdown, 6 suspend, 7 wake
  int ph = 0, tm = 0;
  bit mlock = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; tm = 0; mlock = 0;
    end else begin
      int np;
      bit nl;
      np = ph;
      nl = mlock;
      if (ph == 0) begin
        if (req_sleep) np = banks_idle ? 1 : 0;
        else if (req_pdown) np = (banks_idle && !mlock) ? 5 : 0;
        else if (req_susp && burst_active && !mlock) np = 6;
        if (!req_pdown && !req_susp) nl = 0;
      end else if (ph == 1) np = 2;
      else if (ph == 2) begin if (!req_sleep) np = 3; end
      else if (ph == 3) begin if (tm == TRC - 1) np = 4; end
      else if (ph == 4) begin if (tm == NREF * TRC) np = 0; end
      else if (ph == 5 || ph == 6) begin
        bit h;
        h = (ph == 5) ? req_pdown : req_susp;
        if (!h) np = 7;
        else if (tm == WIN - 1) begin np = 7; nl = 1; end
      end else if (ph == 7) begin if (tm == TCKA - 1) np = 0; end
      tm = (np == ph) ? tm + 1 : 0;
      ph = np;
      mlock = nl;
    end
  end

  function automatic int exp_pins();
    case (ph)
      0: return 5'b11111;
      1: return 5'b00001;
      2, 5, 6: return 5'b01111;
      3, 7: return 5'b10111;
      4: return ((tm % TRC == 0) && (tm < NREF * TRC)) ? 5'b10001 : 5'b10111;
      default: return 0;
    endcase
  endfunction

  function automatic string ph_req();
    case (ph)
      0: return "R1";  1, 2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";     default: return "R8";
    endcase
  endfunction

  // per-cycle comparison (outputs depend on state only)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int a;
      a = {cke, cs_n, ras_n, cas_n, we_n};
      chk(a == exp_pins(), ph_req(), a, exp_pins());
      chk(busy == (ph != 0), "R11", busy, ph != 0);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int pins();
    return {cke, cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic summary();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    tick(3);
    chk(pins() == 5'b11111 && busy == 0, "R1", pins(), 5'b11111);
    rst_n = 1;
    tick(2);
    chk(pins() == 5'b11111 && busy == 0, "R1", pins(), 5'b11111);

    // self-refresh: blocked without idle banks, then entered
    req_sleep = 1; banks_idle = 0;
    tick(3);
    chk(cke == 1, "R2", cke, 1);
    banks_idle = 1;
    tick(1);
    chk(pins() == 5'b00001, "R2", pins(), 5'b00001);
    tick(1);
    chk(pins() == 5'b01111, "R2", pins(), 5'b01111);
    tick(4);
    req_sleep = 0;
    tick(1);
    chk(pins() == 5'b10111 && busy, "R3", pins(), 5'b10111);
    begin
      int arefs = 0, guard = 0;
      while (busy && guard < 200) begin
        if (pins() == 5'b10001) arefs++;
        chk(busy == 1, "R11", busy, 1);
        tick(1); guard++;
      end
      chk(arefs == NREF, "R4", arefs, NREF);
    end

    // power-down not entered while banks busy
    req_pdown = 1; banks_idle = 0;
    tick(3);
    chk(cke == 1, "R5", cke, 1);
    // power-down entered, other inputs ignored
    banks_idle = 1;
    tick(1);
    chk(cke == 0, "R5", cke, 0);
    banks_idle = 0; burst_active = 1; req_susp = 1; req_sleep = 1;
    tick(3);
    chk(pins() == 5'b01111, "R7", pins(), 5'b01111);
    req_sleep = 0; req_susp = 0; burst_active = 0; banks_idle = 1;
    req_pdown = 0;
    tick(1);
    chk(pins() == 5'b10111, "R8", pins(), 5'b10111);
    tick(TCKA);
    chk(busy == 0, "R8", busy, 0);

    // clock suspend during a burst
    req_susp = 1; burst_active = 1; banks_idle = 0;
    tick(1);
    chk(cke == 0, "R6", cke, 0);
    tick(3);
    req_susp = 0;
    tick(1 + TCKA);
    chk(busy == 0 && cke == 1, "R8", busy, 0);
    burst_active = 0; banks_idle = 1;

    // deadline forced wake and lock
    req_pdown = 1;
    tick(1);
    begin
      int low = 0;
      while (cke == 0 && low < 200) begin low++; tick(1); end
      chk(low == WIN, "R9", low, WIN);
    end
    tick(10);
    chk(cke == 1 && busy == 0, "R10", cke, 1);
    req_pdown = 0;
    tick(1);
    req_pdown = 1;
    tick(1);
    chk(cke == 0, "R10", cke, 0);
    req_pdown = 0;
    tick(1 + TCKA + 1);

    // request ranking
    req_sleep = 1; req_pdown = 1; req_susp = 1; banks_idle = 0; burst_active = 1;
    tick(3);
    chk(cke == 1, "R12", cke, 1);
    req_sleep = 0;
    tick(3);
    chk(cke == 1, "R12", cke, 1);
    req_pdown = 0;
    tick(1);
    chk(cke == 0, "R12", cke, 0);
    req_susp = 0; burst_active = 0;
    tick(1 + TCKA + 1);
    req_sleep = 1; req_pdown = 1; banks_idle = 1;
    tick(1);
    chk(pins() == 5'b00001, "R12", pins(), 5'b00001);
    req_sleep = 0; req_pdown = 0;
    begin
      int guard = 0;
      while (busy && guard < 200) begin tick(1); guard++; end
    end
    tick(2);
    chk(pins() == 5'b11111 && busy == 0, "R1", pins(), 5'b11111);
    summary();
  end
endmodule